// File: doc/BRIEF.md
# Shared-Port Wormhole Input Group

This block is the receive side of one direction of a router whose incoming links are one-to-many express channels. Every channel that ends at this router has its own input port, and each port holds exactly one flit queue. All ports of the direction feed one shared crossbar input. A simple ready/valid pair stands in for that crossbar input. The block buffers arriving flits. It returns one credit upstream for each flit it removes from a queue. It works out the dimension-order output direction from the destination in a head flit. It gives the shared port to one packet at a time and keeps it from the head flit through the tail flit.

Each flit carries a head marker and a tail marker, and a one-flit packet sets both. A head flit also carries the destination column and row. The direction is resolved in X before Y and is computed once, at the head. Every later flit of the packet carries that same direction on the output, so the switch stage never decodes addresses. Senders start with as many credits as a queue has slots, so a queue never needs to refuse a flit. When a packet ends, the next packet is chosen round-robin among the ports whose queue front is a head flit.

Top module: `wh_input_group`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` and every `credit_out` bit are 0.
- R2: Flits from one input port leave on the shared port in the order in which they arrived.
- R3: Each input port raises `credit_out[i]` for exactly one cycle per flit taken from its queue. The pulse appears in the same cycle that the flit first shows on the output with `out_port` equal to i. Over a run, the credits returned equal the flits sent.
- R4: Once a head flit without its tail marker has been presented, every following flit on the shared port comes from the same port until a tail flit has been accepted. This holds even while that port's queue is empty and other ports wait.
- R5: The first flit presented after reset, and after each accepted tail flit, is a head flit.
- R6: Flit layout, with FLIT_W = 2+XW+YW+PW: bit FLIT_W-1 is head, bit FLIT_W-2 is tail, the next XW bits are the destination X, the next YW bits are the destination Y, and the low PW bits are payload. `out_dir` encodes 0 local, 1 +X, 2 −X, 3 +Y, 4 −Y. If dest X differs from HERE_X, the direction is +X or −X, whatever Y is. Otherwise +Y or −Y applies if dest Y differs from HERE_Y, and local applies if neither differs. Every flit of a packet carries the direction computed from its head.
- R7: When the shared port is free, the next packet comes from the first port with a head flit ready, searching upward (with wrap) from the port after the last winner. After reset, port 0 has the highest priority.
- R8: While `out_valid` is high and `out_ready` is low, `out_flit`, `out_dir` and `out_port` hold their values.
- R9: A sender that keeps within DEPTH credits never writes into a full queue. A queue holds DEPTH flits while the shared port stalls.
- R10: A one-flit packet (head and tail both set) frees the shared port at once, so a packet from another port may follow directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NPORT | Flit strobe, one per input port |
| in_flit | input | NPORT*FLIT_W | Flits, port i in bits [i*FLIT_W +: FLIT_W] |
| credit_out | output | NPORT | One-cycle credit pulse per dequeued flit, per port |
| out_valid | output | 1 | Shared port holds a flit |
| out_ready | input | 1 | Crossbar accepts the flit this cycle |
| out_flit | output | FLIT_W | Flit on the shared port |
| out_dir | output | 3 | Output direction of the packet |
| out_port | output | PORT_W | Input port the flit came from |

## Verification
Single-flit packets are sent to destinations on each side of the router, including ones that differ in both X and Y, to tell an X-first routing decision apart from a Y-first one. Heads arriving on all ports in the same cycle, with the output stalled, show the rotation order and whether a one-flit packet frees the port. They also show whether the output holds still under backpressure. A packet whose tail arrives late, while another port waits, tells true wormhole ownership apart from flit-level interleaving. A burst that fills a queue to its depth checks ordering and credit accounting at full occupancy.

// File: rtl/wh_pkg.sv
package wh_pkg;
  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_XPOS  = 3'd1,
    DIR_XNEG  = 3'd2,
    DIR_YPOS  = 3'd3,
    DIR_YNEG  = 3'd4
  } dir_t;
endpackage

// File: rtl/wh_flit_fifo.sv
module wh_flit_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = mem[rd_ptr];

  // storage without reset so that RAM inference stays possible
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wh_rr_pick.sv
module wh_rr_pick #(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] gnt,
  output logic          any
);
  always_comb begin
    gnt = '0;
    any = 1'b0;
    // walk from the farthest candidate to the nearest so the nearest wins
    for (int off = N; off >= 1; off--) begin
      int idx;
      idx = (int'(last) + off) % N;
      if (req[idx]) begin
        gnt = IW'(idx);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wh_dor_route.sv
module wh_dor_route
  import wh_pkg::*;
#(
  parameter int XW     = 3,
  parameter int YW     = 3,
  parameter int HERE_X = 2,
  parameter int HERE_Y = 2
) (
  input  logic [XW-1:0] dest_x,
  input  logic [YW-1:0] dest_y,
  output dir_t          dir
);
  localparam logic [XW-1:0] MX = XW'(HERE_X);
  localparam logic [YW-1:0] MY = YW'(HERE_Y);

  always_comb begin
    if (dest_x > MX)      dir = DIR_XPOS;
    else if (dest_x < MX) dir = DIR_XNEG;
    else if (dest_y > MY) dir = DIR_YPOS;
    else if (dest_y < MY) dir = DIR_YNEG;
    else                  dir = DIR_LOCAL;
  end
endmodule

// File: rtl/wh_input_group.sv
module wh_input_group
  import wh_pkg::*;
#(
  parameter int NPORT  = 3,
  parameter int DEPTH  = 10,
  parameter int XW     = 3,
  parameter int YW     = 3,
  parameter int PW     = 16,
  parameter int HERE_X = 2,
  parameter int HERE_Y = 2,
  localparam int FLIT_W = 2 + XW + YW + PW,
  localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        in_valid,
  input  logic [NPORT*FLIT_W-1:0] in_flit,
  output logic [NPORT-1:0]        credit_out,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [FLIT_W-1:0]       out_flit,
  output logic [2:0]              out_dir,
  output logic [PORT_W-1:0]       out_port
);
  localparam int HEAD_B = FLIT_W - 1;
  localparam int TAIL_B = FLIT_W - 2;
  localparam int X_LSB  = PW + YW;
  localparam int Y_LSB  = PW;

  logic [FLIT_W-1:0] q_dout [NPORT];
  logic [NPORT-1:0]  fifo_full, fifo_empty, pop, head_req;

  logic [PORT_W-1:0] last_q, owner_q, gnt, sel;
  logic              locked_q, any_head, load, go;
  dir_t              dir_q, route_dir, dir_next;
  logic [FLIT_W-1:0] sel_flit;

  logic              out_valid_q;
  logic [FLIT_W-1:0] out_flit_q;
  dir_t              out_dir_q;
  logic [PORT_W-1:0] out_port_q;
  logic [NPORT-1:0]  credit_q;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    wh_flit_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst   (rst),
      .push  (in_valid[i]),
      .din   (in_flit[i*FLIT_W +: FLIT_W]),
      .pop   (pop[i]),
      .dout  (q_dout[i]),
      .full  (fifo_full[i]),
      .empty (fifo_empty[i])
    );
    assign head_req[i] = !fifo_empty[i] && q_dout[i][HEAD_B];
    assign pop[i]      = go && (sel == PORT_W'(i));
  end

  wh_rr_pick #(.N(NPORT), .IW(PORT_W)) u_pick (
    .req  (head_req),
    .last (last_q),
    .gnt  (gnt),
    .any  (any_head)
  );

  assign sel      = locked_q ? owner_q : gnt;
  assign sel_flit = q_dout[sel];
  assign load     = !out_valid_q || out_ready;
  assign go       = load && (locked_q ? !fifo_empty[owner_q] : any_head);

  wh_dor_route #(.XW(XW), .YW(YW), .HERE_X(HERE_X), .HERE_Y(HERE_Y)) u_route (
    .dest_x (sel_flit[X_LSB +: XW]),
    .dest_y (sel_flit[Y_LSB +: YW]),
    .dir    (route_dir)
  );

  assign dir_next = locked_q ? dir_q : route_dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_flit_q  <= '0;
      out_dir_q   <= DIR_LOCAL;
      out_port_q  <= '0;
      credit_q    <= '0;
      locked_q    <= 1'b0;
      owner_q     <= '0;
      dir_q       <= DIR_LOCAL;
      last_q      <= PORT_W'(NPORT - 1);
    end else begin
      credit_q <= pop;
      if (go) begin
        out_valid_q <= 1'b1;
        out_flit_q  <= sel_flit;
        out_dir_q   <= dir_next;
        out_port_q  <= sel;
        locked_q    <= !sel_flit[TAIL_B];
        if (!locked_q) begin
          last_q  <= gnt;
          owner_q <= gnt;
          dir_q   <= route_dir;
        end
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid  = out_valid_q;
  assign out_flit   = out_flit_q;
  assign out_dir    = out_dir_q;
  assign out_port   = out_port_q;
  assign credit_out = credit_q;
endmodule

// File: rtl/wh_input_group_chk.sv
module wh_input_group_chk #(
  parameter int NPORT  = 3,
  parameter int FLIT_W = 24,
  parameter int PORT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NPORT-1:0]  in_valid,
  input logic [NPORT-1:0]  fifo_full,
  input logic [NPORT-1:0]  credit_out,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FLIT_W-1:0] out_flit,
  input logic [2:0]        out_dir,
  input logic [PORT_W-1:0] out_port
);
  logic              open_q;
  logic [PORT_W-1:0] open_port;
  logic [2:0]        open_dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      open_port <= '0;
      open_dir  <= '0;
    end else if (out_valid && out_ready) begin
      if (out_flit[FLIT_W-2]) begin
        open_q <= 1'b0;
      end else if (out_flit[FLIT_W-1]) begin
        open_q    <= 1'b1;
        open_port <= out_port;
        open_dir  <= out_dir;
      end
    end
  end

  // R4
  no_interleave_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && open_q |-> out_port == open_port);

  // R5
  head_first_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !open_q |-> out_flit[FLIT_W-1]);

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && open_q |-> out_dir == open_dir);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_flit) && $stable(out_port) && $stable(out_dir));

  for (genvar i = 0; i < NPORT; i++) begin : g_p
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid[i] |-> !fifo_full[i]);
    // R3
    credit_chk: assert property (@(posedge clk) disable iff (rst)
      credit_out[i] |-> out_valid && out_port == PORT_W'(i));
  end
endmodule

bind wh_input_group wh_input_group_chk #(
  .NPORT  (NPORT),
  .FLIT_W (FLIT_W),
  .PORT_W (PORT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .fifo_full  (fifo_full),
  .credit_out (credit_out),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_flit   (out_flit),
  .out_dir    (out_dir),
  .out_port   (out_port)
);

// File: tb/wh_input_group_test.sv
`timescale 1ns/1ps
module wh_input_group_test;
  localparam int NP = 3, DP = 10, XW = 3, YW = 3, PW = 16;
  localparam int FW = 2 + XW + YW + PW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] in_valid = '0;
  logic [NP*FW-1:0] in_flit = '0;
  logic [NP-1:0] credit_out;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [FW-1:0] out_flit;
  logic [2:0]    out_dir;
  logic [1:0]    out_port;

  int total = 0, failed = 0;
  int n_cap = 0;
  logic [FW-1:0] cap_flit [64];
  logic [2:0]    cap_dir  [64];
  logic [1:0]    cap_port [64];
  int sent [NP];
  int back [NP];

  always #2.5 clk = ~clk;

  wh_input_group #(.NPORT(NP), .DEPTH(DP), .XW(XW), .YW(YW), .PW(PW),
                   .HERE_X(2), .HERE_Y(2)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
    .credit_out(credit_out), .out_valid(out_valid), .out_ready(out_ready),
    .out_flit(out_flit), .out_dir(out_dir), .out_port(out_port));

  initial for (int i = 0; i < NP; i++) begin sent[i] = 0; back[i] = 0; end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready && n_cap < 64) begin
        cap_flit[n_cap] = out_flit;
        cap_dir[n_cap]  = out_dir;
        cap_port[n_cap] = out_port;
        n_cap = n_cap + 1;
      end
      for (int i = 0; i < NP; i++) if (credit_out[i]) back[i] = back[i] + 1;
    end
  end

  function automatic logic [FW-1:0] mk(logic h, logic t, int x, int y, int p);
    return {h, t, 3'(x), 3'(y), 16'(p)};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // drive one cycle of flits on the ports selected by v
  task automatic push(logic [NP-1:0] v, logic [FW-1:0] a, logic [FW-1:0] b, logic [FW-1:0] c);
    for (int i = 0; i < NP; i++) if (v[i]) begin
      check(sent[i] - back[i] < DP, "R9 credit available", sent[i] - back[i], DP - 1);
      sent[i]++;
    end
    in_valid = v;
    in_flit  = {c, b, a};
    step();
    in_valid = '0;
  endtask

  task automatic wait_cap(int n);
    for (int k = 0; k < 300 && n_cap < n; k++) step();
  endtask

  task automatic expect_cap(int idx, logic [FW-1:0] f, int port, string tag);
    check(cap_flit[idx] == f, tag, int'(cap_flit[idx][15:0]), int'(f[15:0]));
    check(int'(cap_port[idx]) == port, tag, int'(cap_port[idx]), port);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    step();
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(credit_out == '0, "R1 credit after reset", int'(credit_out), 0);
  endtask

  task automatic t_route();
    int xs [7] = '{5, 0, 2, 2, 2, 6, 1};
    int ys [7] = '{2, 2, 6, 0, 2, 0, 7};
    int ds [7] = '{1, 2, 3, 4, 0, 1, 2};
    for (int k = 0; k < 7; k++) begin
      int base;
      base = n_cap;
      push(3'b001, mk(1, 1, xs[k], ys[k], 100 + k), '0, '0);
      wait_cap(base + 1);
      check(int'(cap_dir[base]) == ds[k], "R6 X-first direction", int'(cap_dir[base]), ds[k]);
    end
  endtask

  task automatic t_rotate();
    int base;
    logic [FW-1:0] a0, a1, b0, b1, c0;
    a0 = mk(1, 0, 5, 2, 200); a1 = mk(0, 1, 0, 0, 201);
    b0 = mk(1, 0, 2, 0, 210); b1 = mk(0, 1, 7, 7, 211);
    c0 = mk(1, 1, 0, 5, 220);
    base = n_cap;
    out_ready = 1'b0;
    push(3'b111, a0, b0, c0);
    push(3'b011, a1, b1, '0);
    step(); step();
    check(out_valid && out_flit == b0, "R7 port1 wins after port0", int'(out_flit[15:0]), 210);
    check(int'(out_port) == 1, "R7 winner port", int'(out_port), 1);
    step(); step();
    check(out_flit == b0, "R8 held under stall", int'(out_flit[15:0]), 210);
    out_ready = 1'b1;
    wait_cap(base + 5);
    expect_cap(base + 0, b0, 1, "R7 order 1");
    expect_cap(base + 1, b1, 1, "R4 tail follows head");
    check(int'(cap_dir[base + 1]) == 4, "R6 body keeps head dir", int'(cap_dir[base + 1]), 4);
    expect_cap(base + 2, c0, 2, "R10 one-flit packet");
    expect_cap(base + 3, a0, 0, "R10 next packet follows directly");
    expect_cap(base + 4, a1, 0, "R5 packet completes");
  endtask

  task automatic t_late_tail();
    int base;
    logic [FW-1:0] h, t, o;
    h = mk(1, 0, 2, 6, 300); t = mk(0, 1, 0, 0, 301); o = mk(1, 1, 0, 0, 310);
    base = n_cap;
    push(3'b001, h, '0, '0);
    push(3'b010, '0, o, '0);
    for (int k = 0; k < 6; k++) step();
    check(n_cap == base + 1, "R4 other port waits for tail", n_cap - base, 1);
    push(3'b001, t, '0, '0);
    wait_cap(base + 3);
    expect_cap(base + 0, h, 0, "R4 head");
    expect_cap(base + 1, t, 0, "R4 late tail");
    expect_cap(base + 2, o, 1, "R4 waiting packet");
  endtask

  task automatic t_fill();
    int base, b0;
    base = n_cap;
    b0 = back[1];
    out_ready = 1'b0;
    for (int k = 0; k < DP; k++)
      push(3'b010, '0, mk(k == 0, k == DP - 1, 6, 6, 400 + k), '0);
    step(); step();
    check(back[1] - b0 == 1, "R3 one credit while stalled", back[1] - b0, 1);
    out_ready = 1'b1;
    wait_cap(base + DP);
    for (int k = 0; k < DP; k++)
      check(int'(cap_flit[base + k][15:0]) == 400 + k, "R2 per-port order",
            int'(cap_flit[base + k][15:0]), 400 + k);
  endtask

  task automatic t_credits();
    for (int k = 0; k < 4; k++) step();
    for (int i = 0; i < NP; i++)
      check(back[i] == sent[i], "R3 credits equal flits", back[i], sent[i]);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_route();
    t_rotate();
    t_late_tail();
    t_fill();
    t_credits();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule